// File: doc/BRIEF.md
# Weighted Transition Coverage Monitor

This block watches a finite state machine while a functional test sequence runs. Every clock cycle it treats the machine's current state code together with the primary input vector as one vertex. A vertex is heavy (weight 1) when it equals one of a handful of preferred patterns held in a small table. All other vertices are light (weight 0). The block remembers which vertices the sequence has reached. It also records the largest edge weight seen entering each vertex. An edge weight is the bit distance between two consecutive vertices when the later one is heavy, and zero otherwise.

Four counters come out of the block. The one-state pair gives heavy vertices reached over all heavy vertices. The two-state pair gives the sum of the best entering weights over the sum of the best entering weights achievable. Software would divide these to get percentages, and that division stays outside this block. The preferred patterns and the achievable entering weights are written through a single write port before a run. A clear input starts a new run without touching either table.

Top module: `wtc_monitor`

## Requirements
- R1: After reset all four counters read zero, the pattern table holds no valid entry and every achievable-weight entry is zero.
- R2: A vertex has weight 1 exactly when some pattern entry has its valid bit set and a code equal to the vertex. `cov1_den` counts such vertices once each, so duplicate entries and entries with the valid bit clear add nothing.
- R3: `cov1_num` counts the distinct heavy vertices sampled since the last reset or clear. Revisiting a vertex or visiting a light vertex leaves it unchanged.
- R4: The vertex code is `{cur_state, cur_in}` with the state in the upper bits. The edge weight into a heavy vertex is the number of bit positions in which its code differs from the code of the vertex sampled one cycle earlier. The edge weight into a light vertex is 0.
- R5: `cov2_num` is the sum over all vertices of the largest edge weight that has entered that vertex. A later, smaller entering weight does not lower the stored value.
- R6: `cov2_den` is the sum of the achievable entering weights that have been written, and it changes only through a write.
- R7: The first vertex sampled after reset or after a clear has no predecessor and contributes an edge weight of 0.
- R8: While `clr` is high no vertex is sampled, and the clock edge that sees `clr` high zeroes `cov1_num` and `cov2_num` while both tables and both denominators keep their values.
- R9: A vertex presented at a clock edge with `clr` low is reflected in the counters right after that edge, with no further delay.
- R10: A write with `wr_tgt`=0 loads pattern entry `wr_addr` (low bits) with valid bit `wr_data[VW]` and code `wr_data[VW-1:0]`. A write with `wr_tgt`=1 loads the achievable entering weight of vertex `wr_addr` from `wr_data[WW-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start a new run: drop coverage and predecessor, hold sampling |
| cur_state | input | SW | State code of the watched machine |
| cur_in | input | IW | Primary input vector applied this cycle |
| wr_en | input | 1 | Table write strobe |
| wr_tgt | input | 1 | 0 selects the pattern table, 1 the achievable-weight table |
| wr_addr | input | AW | Pattern entry index or vertex code |
| wr_data | input | VW+1 | Valid bit and code, or achievable weight in the low bits |
| cov1_num | output | C1W | Heavy vertices reached |
| cov1_den | output | C1W | Heavy vertices in total |
| cov2_num | output | C2W | Sum of best entering weights seen |
| cov2_den | output | C2W | Sum of achievable entering weights |

## Verification
The bench uses a 2-bit state and a 1-bit input, so there are eight vertices. It first replays the short four-vertex sequence whose counters are known by hand (2 of 2, and 4 of 5). This pins down the bit order of the code and the distance rule. Next it runs every ordered pair of vertices after a clear. That separates a wrong distance, a missed light-vertex zero and a first-vertex edge that should not count. A long pseudo-random walk over two different pattern tables then exposes faults in keeping the maximum and in deduplicating revisits. Table writes with the valid bit clear, and with a duplicate code, show whether the one-state denominator counts vertices rather than entries.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  // widest vertex code the helper functions accept
  localparam int CODE_MAX = 16;
  typedef logic [CODE_MAX-1:0] code_t;

  // number of differing bit positions between two vertex codes
  function automatic int unsigned bit_distance(input code_t a, input code_t b);
    int unsigned n;
    code_t d;
    n = 0;
    d = a ^ b;
    for (int i = 0; i < CODE_MAX; i++) begin
      n += 32'(d[i]);
    end
    return n;
  endfunction

  // larger of two stored weights
  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wtc_pattern_table.sv
module wtc_pattern_table #(
  parameter int VW   = 8,
  parameter int NPAT = 8,
  localparam int PAW = $clog2(NPAT),
  localparam int NV  = 1 << VW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pat_we,
  input  logic [PAW-1:0] pat_addr,
  input  logic [VW:0]   pat_data,
  output logic [NV-1:0] vtx_weight
);

  logic          ent_valid [NPAT];
  logic [VW-1:0] ent_code  [NPAT];

  for (genvar p = 0; p < NPAT; p++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[p] <= 1'b0;
        ent_code[p]  <= '0;
      end else if (pat_we && pat_addr == PAW'(p)) begin
        ent_valid[p] <= pat_data[VW];
        ent_code[p]  <= pat_data[VW-1:0];
      end
    end
  end

  // each vertex is heavy when any valid entry names it
  for (genvar v = 0; v < NV; v++) begin : g_vtx
    always_comb begin
      vtx_weight[v] = 1'b0;
      for (int p = 0; p < NPAT; p++) begin
        if (ent_valid[p] && ent_code[p] == VW'(v)) vtx_weight[v] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wtc_vertex_store.sv
module wtc_vertex_store #(
  parameter int VW = 8,
  localparam int NV  = 1 << VW,
  localparam int WW  = $clog2(VW + 1),
  localparam int C1W = $clog2(NV + 1),
  localparam int C2W = WW + VW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           smp,
  input  logic [VW-1:0]  vtx,
  input  logic [WW-1:0]  edge_w,
  input  logic [NV-1:0]  vtx_weight,
  input  logic           mx_we,
  input  logic [VW-1:0]  mx_addr,
  input  logic [WW-1:0]  mx_data,
  output logic [C1W-1:0] num1,
  output logic [C1W-1:0] den1,
  output logic [C2W-1:0] num2,
  output logic [C2W-1:0] den2
);

  logic [NV-1:0] covered;
  logic [WW-1:0] best   [NV];
  logic [WW-1:0] reach  [NV];

  for (genvar v = 0; v < NV; v++) begin : g_vtx
    logic hit;
    assign hit = smp && (vtx == VW'(v));

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        covered[v] <= 1'b0;
        best[v]    <= '0;
      end else if (hit) begin
        covered[v] <= 1'b1;
        best[v]    <= WW'(wtc_pkg::wmax(32'(best[v]), 32'(edge_w)));
      end
    end

    always_ff @(posedge clk) begin
      if (rst) reach[v] <= '0;
      else if (mx_we && mx_addr == VW'(v)) reach[v] <= mx_data;
    end
  end

  always_comb begin
    num1 = '0;
    den1 = '0;
    num2 = '0;
    den2 = '0;
    for (int v = 0; v < NV; v++) begin
      num1 += C1W'(covered[v] & vtx_weight[v]);
      den1 += C1W'(vtx_weight[v]);
      num2 += C2W'(best[v]);
      den2 += C2W'(reach[v]);
    end
  end

endmodule

// File: rtl/wtc_monitor.sv
module wtc_monitor #(
  parameter int SW   = 4,
  parameter int IW   = 4,
  parameter int NPAT = 8,
  localparam int VW  = SW + IW,
  localparam int NV  = 1 << VW,
  localparam int WW  = $clog2(VW + 1),
  localparam int PAW = $clog2(NPAT),
  localparam int AW  = (VW > PAW) ? VW : PAW,
  localparam int C1W = $clog2(NV + 1),
  localparam int C2W = WW + VW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [SW-1:0]  cur_state,
  input  logic [IW-1:0]  cur_in,
  input  logic           wr_en,
  input  logic           wr_tgt,
  input  logic [AW-1:0]  wr_addr,
  input  logic [VW:0]    wr_data,
  output logic [C1W-1:0] cov1_num,
  output logic [C1W-1:0] cov1_den,
  output logic [C2W-1:0] cov2_num,
  output logic [C2W-1:0] cov2_den
);

  logic [VW-1:0] vtx;
  logic [VW-1:0] prev_vtx;
  logic          have_prev;
  logic          smp;
  logic [NV-1:0] vtx_weight;
  logic          vtx_heavy;
  logic [WW-1:0] edge_w;
  logic          pat_we;
  logic          mx_we;

  assign vtx       = {cur_state, cur_in};
  assign smp       = !clr;
  assign pat_we    = wr_en && !wr_tgt;
  assign mx_we     = wr_en && wr_tgt;
  assign vtx_heavy = vtx_weight[vtx];

  // predecessor of the next sampled vertex
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_vtx  <= '0;
      have_prev <= 1'b0;
    end else begin
      prev_vtx  <= vtx;
      have_prev <= 1'b1;
    end
  end

  always_comb begin
    edge_w = '0;
    if (have_prev && vtx_heavy)
      edge_w = WW'(wtc_pkg::bit_distance(wtc_pkg::code_t'(prev_vtx), wtc_pkg::code_t'(vtx)));
  end

  wtc_pattern_table #(.VW(VW), .NPAT(NPAT)) u_pat (
    .clk        (clk),
    .rst        (rst),
    .pat_we     (pat_we),
    .pat_addr   (wr_addr[PAW-1:0]),
    .pat_data   (wr_data),
    .vtx_weight (vtx_weight)
  );

  wtc_vertex_store #(.VW(VW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .smp        (smp),
    .vtx        (vtx),
    .edge_w     (edge_w),
    .vtx_weight (vtx_weight),
    .mx_we      (mx_we),
    .mx_addr    (wr_addr[VW-1:0]),
    .mx_data    (wr_data[WW-1:0]),
    .num1       (cov1_num),
    .den1       (cov1_den),
    .num2       (cov2_num),
    .den2       (cov2_den)
  );

endmodule

// File: rtl/wtc_monitor_chk.sv
module wtc_monitor_chk #(
  parameter int VW  = 8,
  parameter int WW  = 4,
  parameter int C1W = 9,
  parameter int C2W = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           clr,
  input logic           wr_en,
  input logic           have_prev,
  input logic           vtx_heavy,
  input logic [WW-1:0]  edge_w,
  input logic [C1W-1:0] cov1_num,
  input logic [C1W-1:0] cov1_den,
  input logic [C2W-1:0] cov2_num,
  input logic [C2W-1:0] cov2_den
);

  AST_NUM1_WITHIN_DEN1: assert property (@(posedge clk) disable iff (rst)
    cov1_num <= cov1_den); // R3

  AST_NUM1_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !wr_en) |=> cov1_num >= $past(cov1_num)); // R3

  AST_EDGE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    32'(edge_w) <= VW); // R4

  AST_LIGHT_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !vtx_heavy |-> edge_w == '0); // R4

  AST_NUM2_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cov2_num >= $past(cov2_num)); // R5

  AST_DEN2_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cov2_den)); // R6

  AST_FIRST_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !have_prev |-> edge_w == '0); // R7

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cov1_num == '0 && cov2_num == '0)); // R8

endmodule

bind wtc_monitor wtc_monitor_chk #(.VW(VW), .WW(WW), .C1W(C1W), .C2W(C2W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .wr_en     (wr_en),
  .have_prev (have_prev),
  .vtx_heavy (vtx_heavy),
  .edge_w    (edge_w),
  .cov1_num  (cov1_num),
  .cov1_den  (cov1_den),
  .cov2_num  (cov2_num),
  .cov2_den  (cov2_den)
);

// File: tb/tb_wtc_monitor.sv
`timescale 1ns/1ps
module tb_wtc_monitor;

  localparam int SW = 2, IW = 1, NPAT = 4;
  localparam int VW = SW + IW, NV = 8, AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b1;
  logic [SW-1:0] cur_state = '0;
  logic [IW-1:0] cur_in = '0;
  logic wr_en = 1'b0, wr_tgt = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [VW:0] wr_data = '0;
  logic [3:0] cov1_num, cov1_den;
  logic [4:0] cov2_num, cov2_den;

  always #4 clk = ~clk;

  wtc_monitor #(.SW(SW), .IW(IW), .NPAT(NPAT)) dut (
    .clk(clk), .rst(rst), .clr(clr), .cur_state(cur_state), .cur_in(cur_in),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data),
    .cov1_num(cov1_num), .cov1_den(cov1_den), .cov2_num(cov2_num), .cov2_den(cov2_den)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  bit m_pv [NPAT];
  int m_pc [NPAT];
  int m_mx [NV];
  bit m_cov [NV];
  int m_best [NV];
  bit m_hp;
  int m_prev;

  function automatic bit heavy(int v);
    for (int p = 0; p < NPAT; p++) if (m_pv[p] && m_pc[p] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int ones(int x);
    int n = 0;
    while (x != 0) begin x = x & (x - 1); n++; end
    return n;
  endfunction

  function automatic int e_num1();
    int s = 0;
    for (int v = 0; v < NV; v++) if (m_cov[v] && heavy(v)) s++;
    return s;
  endfunction
  function automatic int e_den1();
    int s = 0;
    for (int v = 0; v < NV; v++) if (heavy(v)) s++;
    return s;
  endfunction
  function automatic int e_num2();
    int s = 0;
    for (int v = 0; v < NV; v++) s += m_best[v];
    return s;
  endfunction
  function automatic int e_den2();
    int s = 0;
    for (int v = 0; v < NV; v++) s += m_mx[v];
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(cov1_num == 4'(e_num1()), {req, " cov1_num"}, int'(cov1_num), e_num1());
    chk(cov1_den == 4'(e_den1()), {req, " cov1_den"}, int'(cov1_den), e_den1());
    chk(cov2_num == 5'(e_num2()), {req, " cov2_num"}, int'(cov2_num), e_num2());
    chk(cov2_den == 5'(e_den2()), {req, " cov2_den"}, int'(cov2_den), e_den2());
  endtask

  task automatic model_clear();
    for (int v = 0; v < NV; v++) begin m_cov[v] = 0; m_best[v] = 0; end
    m_hp = 0;
    m_prev = 0;
  endtask

  // table write; clr held high so nothing is sampled meanwhile
  task automatic write(bit tgt, int addr, int data);
    @(negedge clk);
    clr = 1; wr_en = 1; wr_tgt = tgt; wr_addr = 3'(addr); wr_data = 4'(data);
    @(posedge clk);
    if (!tgt) begin m_pv[addr % NPAT] = data[VW]; m_pc[addr % NPAT] = data & 7; end
    else m_mx[addr] = data & 3;
    model_clear();
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_clear(string req);
    @(negedge clk);
    clr = 1;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    chk_all(req);
    clr = 0;
  endtask

  // present vertex v for one edge; counters checked right after it (R9)
  task automatic vstep(int v, string req);
    int e;
    cur_state = 2'(v >> 1);
    cur_in = 1'(v);
    @(posedge clk);
    e = (m_hp && heavy(v)) ? ones(m_prev ^ v) : 0;
    if (e > m_best[v]) m_best[v] = e;
    m_cov[v] = 1;
    m_prev = v;
    m_hp = 1;
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lfsr;
    for (int p = 0; p < NPAT; p++) begin m_pv[p] = 0; m_pc[p] = 0; end
    for (int v = 0; v < NV; v++) m_mx[v] = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk_all("R1 reset");

    // R10 patterns (10,0)=4 and (10,1)=5, achievable weights 3 and 2
    write(0, 0, 8 | 4);
    write(0, 1, 8 | 5);
    write(1, 4, 3);
    write(1, 5, 2);
    @(negedge clk);
    chk_all("R2 R6 R10 load");

    // worked sequence from reset state 00 with inputs 0,1,0,1
    clr = 0;
    vstep(0, "R7 first vertex");
    vstep(3, "R4 light dest");
    vstep(4, "R4 R9 edge into 4");
    vstep(5, "R4 edge into 5");
    chk(cov1_num == 4'd2 && cov1_den == 4'd2, "R3 worked one-state", int'(cov1_num), 2);
    chk(cov2_num == 5'd4 && cov2_den == 5'd5, "R5 worked two-state", int'(cov2_num), 4);
    vstep(4, "R5 smaller weight keeps max");
    vstep(4, "R3 revisit");

    do_clear("R8 clear");
    chk(cov2_den == 5'd5 && cov1_den == 4'd2, "R8 tables kept", int'(cov2_den), 5);
    vstep(4, "R7 first after clear");

    // R2 invalid and duplicate entries
    write(0, 2, 1);
    @(negedge clk);
    chk_all("R2 invalid entry ignored");
    write(0, 3, 8 | 4);
    @(negedge clk);
    chk_all("R2 duplicate entry");
    write(0, 2, 8 | 7);
    write(1, 7, 3);
    write(1, 0, 1);
    @(negedge clk);
    chk_all("R2 R6 new entry");
    clr = 0;

    // exhaustive ordered pairs
    for (int a = 0; a < NV; a++) begin
      for (int b = 0; b < NV; b++) begin
        do_clear("R8 pair clear");
        vstep(a, "R7 pair first");
        vstep(b, "R4 pair second");
      end
    end

    // long walks over two pattern tables
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 1) begin
        write(0, 0, 8 | 1);
        write(0, 1, 8 | 6);
        write(0, 3, 2);
        write(1, 6, 2);
      end
      do_clear("R8 walk clear");
      lfsr = 8'h5a;
      for (int i = 0; i < 300; i++) begin
        lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hff;
        vstep(lfsr & 7, "R3 R5 walk");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule